// File: doc/BRIEF.md
# Bus Hold Arbiter

The block decides who owns the external address and data buses: the local processor or an outside bus master that asks for them. The outside master raises a hold request, which may arrive at any time relative to the clock. The arbiter synchronizes this request and waits for the bus sequencer to reach the end of the machine cycle in progress. It then raises the hold acknowledge, and one clock later it tells the sequencer to float its bus drivers.

While the buses are held, the arbiter keeps a start-inhibit signal asserted toward the sequencer. No new bus cycle begins, but the core may keep computing internally, and any bus requests it makes simply wait. When the outside master drops its request, the acknowledge falls. The float command is released on the following falling clock edge, so the processor takes the buses back half a clock after the acknowledge drops.

The sequencer tells the arbiter where machine cycles begin and end through two levels. `cyc_busy_i` is high while a cycle runs. `cyc_end_i` is high during the final clock of that cycle.

Top module: `hold_arb`

## Requirements
- R1: `hold_req_i` passes through SYNC_STAGES flip-flops (default 2). With the bus idle, `hold_ack_o` rises on the (SYNC_STAGES+1)th rising edge after the request is set up.
- R2: The acknowledge rises only at a rising edge whose preceding clock was a cycle boundary, meaning `cyc_busy_i` was low or `cyc_end_i` was high. While `cyc_busy_i` is high and `cyc_end_i` is low, a pending request waits.
- R3: `bus_float_o` rises exactly one rising edge after `hold_ack_o` rises.
- R4: After that first clock, `bus_float_o` stays high for as long as `hold_ack_o` is high.
- R5: `hold_ack_o` falls only when the synchronized request is low. With the request dropped, the acknowledge falls on the (SYNC_STAGES+1)th rising edge, provided the hold has already lasted at least two clocks.
- R6: `bus_float_o` falls on the falling clock edge that follows the rising edge at which `hold_ack_o` fell, half a period later.
- R7: `start_inhibit_o` is high whenever the synchronized request, `hold_ack_o` or `bus_float_o` is high, and low otherwise.
- R8: While `rst_ni` is low, all outputs are low and the synchronizer is cleared.
- R9: A new request made right after a release is granted again, with the same latencies as R1 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_req_i | input | 1 | Bus request from outside master, asynchronous |
| cyc_busy_i | input | 1 | A machine cycle is in progress |
| cyc_end_i | input | 1 | Final clock of the current machine cycle |
| hold_ack_o | output | 1 | Hold acknowledge |
| bus_float_o | output | 1 | Command to float address, data, read, write and memory-or-I/O drivers |
| start_inhibit_o | output | 1 | Blocks the sequencer from starting a new cycle |

## Verification
When the bus is idle, the acknowledge is due on the third rising edge after a request change. The float command follows one rising edge after the acknowledge rises. It drops at the falling edge half a clock after the acknowledge falls. The bench drives inputs 2 ns after each rising edge. It samples 1 ns after each rising edge and each falling edge, so every registered and falling-edge result is read in the half period where it is settled. A reference model in the bench advances on the same edges and is compared at every sample, while directed cases count the exact edges from R1, R3, R5 and R6.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_ACK   = 2'd1,
    ARB_FLOAT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/hold_arb_sync.sv
module hold_arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= 1'b0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
  import hold_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       boundary_i,
  output arb_state_e state_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE:  if (req_i && boundary_i) state_d = ARB_ACK;
      ARB_ACK:   state_d = ARB_FLOAT;   // ack leads release by one clock
      ARB_FLOAT: if (!req_i) state_d = ARB_IDLE;
      default:   state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARB_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/hold_arb_float.sv
module hold_arb_float (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic held_i,
  output logic float_o
);
  logic tail_q;

  // falling-edge copy stretches release by half a clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tail_q <= 1'b0;
    else         tail_q <= held_i;
  end

  assign float_o = held_i | tail_q;
endmodule

// File: rtl/hold_arb.sv
module hold_arb
  import hold_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic cyc_busy_i,
  input  logic cyc_end_i,
  output logic hold_ack_o,
  output logic bus_float_o,
  output logic start_inhibit_o
);
  logic       req_sync;
  logic       boundary;
  arb_state_e state;

  hold_arb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hold_req_i),
    .q_o   (req_sync)
  );

  assign boundary = !cyc_busy_i || cyc_end_i;

  hold_arb_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_sync),
    .boundary_i(boundary),
    .state_o   (state)
  );

  hold_arb_float i_float (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .held_i (state == ARB_FLOAT),
    .float_o(bus_float_o)
  );

  assign hold_ack_o      = (state == ARB_ACK) || (state == ARB_FLOAT);
  assign start_inhibit_o = req_sync || hold_ack_o || bus_float_o;
endmodule

// File: rtl/hold_arb_chk.sv
module hold_arb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cyc_busy_i,
  input logic cyc_end_i,
  input logic req_sync_i,
  input logic hold_ack_o,
  input logic bus_float_o,
  input logic start_inhibit_o
);
  assert_grant_on_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(!cyc_busy_i || cyc_end_i));

  assert_ack_before_float_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_float_o) |-> $past(hold_ack_o));

  assert_float_while_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ack_o && $past(hold_ack_o)) |-> bus_float_o);

  assert_release_needs_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_ack_o) |-> !$past(req_sync_i));

  assert_float_drops_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_ack_o) |-> (!bus_float_o && $past(bus_float_o)));

  assert_inhibit_covers_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ack_o || bus_float_o || req_sync_i) |-> start_inhibit_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R8: assert (!hold_ack_o && !bus_float_o && !start_inhibit_o);
    end
  end
endmodule

bind hold_arb hold_arb_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cyc_busy_i     (cyc_busy_i),
  .cyc_end_i      (cyc_end_i),
  .req_sync_i     (req_sync),
  .hold_ack_o     (hold_ack_o),
  .bus_float_o    (bus_float_o),
  .start_inhibit_o(start_inhibit_o)
);

// File: tb/test_hold_arb.sv
`timescale 1ns/1ps
module test_hold_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, busy = 1'b0, cend = 1'b0;
  logic ack, flt, inh;
  int   checks = 0, errors = 0;
  bit   model_on = 1'b0;

  always #4 clk = ~clk;

  hold_arb i_hold_arb (
    .clk_i(clk), .rst_ni(rst_n), .hold_req_i(req), .cyc_busy_i(busy),
    .cyc_end_i(cend), .hold_ack_o(ack), .bus_float_o(flt), .start_inhibit_o(inh)
  );

  // reference model built from the requirements
  logic [1:0] m_sync;
  logic       m_ack, m_fl, m_first;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= '0; m_ack <= 1'b0; m_fl <= 1'b0; m_first <= 1'b0;
    end else begin
      m_sync <= {m_sync[0], req};
      if (!m_ack) begin
        if (m_sync[1] && (!busy || cend)) begin m_ack <= 1'b1; m_first <= 1'b1; end
      end else if (m_first) begin
        m_first <= 1'b0; m_fl <= 1'b1;
      end else if (!m_sync[1]) begin
        m_ack <= 1'b0;
      end
    end
  end
  always @(negedge clk) if (rst_n && !m_ack) m_fl <= 1'b0;

  function automatic logic exp_inh();
    return m_sync[1] || m_ack || m_fl;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R2 ack vs model", ack, m_ack);
    chk("R3 float vs model", flt, m_fl);
    chk("R7 inhibit vs model", inh, exp_inh());
  endtask

  always @(posedge clk) if (model_on) begin #1; cmp_model(); end
  always @(negedge clk) if (model_on) begin #1; chk("R6 float at fall", flt, m_fl); end

  // advance one rising edge, leave at edge+2 ready to drive
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    // R8 reset
    req = 1'b1;
    step(3);
    chk("R8 ack in reset", ack, 1'b0);
    chk("R8 float in reset", flt, 1'b0);
    chk("R8 inhibit in reset", inh, 1'b0);
    req = 1'b0; step(1);
    rst_n = 1'b1; step(3);
    chk("R8 clear after reset", ack, 1'b0);
    model_on = 1'b1;

    // R1 latency, idle bus
    req = 1'b1;
    step(2);
    chk("R1 ack not yet", ack, 1'b0);
    chk("R7 inhibit from sync req", inh, 1'b1);
    step(1);
    chk("R1 ack on third edge", ack, 1'b1);
    chk("R3 float waits one clock", flt, 1'b0);
    step(1);
    chk("R3 float one clock later", flt, 1'b1);
    step(5);
    chk("R4 float held", flt, 1'b1);
    chk("R7 inhibit held", inh, 1'b1);
    // R5 / R6 release
    req = 1'b0;
    step(2);
    chk("R5 ack held until sync low", ack, 1'b1);
    @(posedge clk); #1;
    chk("R5 ack falls", ack, 1'b0);
    chk("R6 float still high", flt, 1'b1);
    @(negedge clk); #1;
    chk("R6 float falls half clock later", flt, 1'b0);
    chk("R7 inhibit cleared", inh, 1'b0);
    @(posedge clk); #2;

    // R2 waits for boundary
    busy = 1'b1; req = 1'b1;
    step(6);
    chk("R2 no grant mid cycle", ack, 1'b0);
    chk("R7 inhibit while waiting", inh, 1'b1);
    cend = 1'b1;
    step(1);
    chk("R2 grant after cycle end", ack, 1'b1);
    cend = 1'b0; busy = 1'b0;
    step(2);
    // R9 release then re-request at once
    req = 1'b0;
    step(3);
    chk("R9 released", ack, 1'b0);
    req = 1'b1;
    step(2);
    chk("R9 not yet regranted", ack, 1'b0);
    step(1);
    chk("R9 regranted", ack, 1'b1);
    step(1);
    chk("R9 float again", flt, 1'b1);
    req = 1'b0; step(4);

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 15) == 0) req = ~req;
      busy = ($urandom_range(0, 3) != 0);
      cend = busy && ($urandom_range(0, 3) == 0);
      step(1);
    end
    req = 1'b0; busy = 1'b0; cend = 1'b0;
    step(6);
    model_on = 1'b0;
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule